// File: doc/BRIEF.md
# Four-Digit Seven-Segment Decoder with Zero Blanking

This block turns a packed decimal value of four BCD digits into segment patterns for a row of four seven-segment displays. A chain of active-low blanking signals runs from the most significant digit down to the least significant one. A zero digit goes dark only while every digit above it is also dark. As a result, leading zeros disappear and zeros between non-zero digits stay visible. A single digit's worth of value (including zero) always leaves one integer digit lit.

A fraction-width input marks how many of the low digits lie to the right of the decimal point. The leading chain stops at the lowest integer digit. A second chain runs from the least significant digit upward and may blank zeros at the right-hand end of the fraction. Integer zeros that fix the point position are never touched. A polarity input selects common-anode drive (segments lit when low) or common-cathode drive (segments lit when high). The patterns are registered on the rising clock edge, and a synchronous reset darkens every digit.

Top module: `rbd_display_decoder`

## Requirements
- R1: Leading-zero blanking: for integer digits above the lowest integer digit, a zero digit is blanked when every digit above it is blanked, with the top digit's chain input held active; the first non-zero digit stops the chain (0100 shows "100", 1024 shows "1024").
- R2: A digit is never blanked unless its value is zero, so zeros between non-zero digits are shown (0905 shows "905").
- R3: The lowest integer digit (digit index equal to fracDigits) is never blanked, so an all-zero value shows a single "0".
- R4: Segment bits are a..g from bit 6 down to bit 0 (active-high form): 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F, 9=7B, A=77, b=1F, C=4E, d=3D, E=4F, F=47 (hex).
- R5: With anodeCommon=1 every segment bit is inverted: lit segments are 0 and a blank digit is all ones; with anodeCommon=0 a blank digit is all zeros.
- R6: Digit i occupies bcdIn[4i+3:4i] and segOut[7i+6:7i], digit 0 least significant; digits with index below fracDigits are fractional and take no part in leading-zero blanking.
- R7: With trailBlankEn=1, fractional zeros are blanked from digit 0 upward until the first non-zero fractional digit; with trailBlankEn=0 every fractional digit is shown.
- R8: Integer digits are never blanked by the trailing chain (0450 with fracDigits=0 shows "450" with trailing blanking enabled).
- R9: segOut takes the pattern for the inputs present at a rising clock edge and holds it until the next edge.
- R10: While rst is high at a rising edge, segOut becomes the all-dark pattern for the current polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, darkens all digits |
| bcdIn | input | 16 | Four packed BCD digits, digit 0 in the low nibble |
| anodeCommon | input | 1 | 1: common-anode drive (active-low segments), 0: common-cathode |
| fracDigits | input | 2 | Number of digits right of the decimal point |
| trailBlankEn | input | 1 | Enables blanking of trailing fractional zeros |
| segOut | output | 28 | Registered segment lines, seven per digit |

## Verification
The hardest case is an interaction of both chains with the point position. Examples are a value whose only non-zero digit sits just above the point, or an all-zero value with three fractional digits. In those cases the leading chain must stop at the lowest integer digit while the trailing chain darkens every digit below it. The stimulus sets fracDigits and trailBlankEn together with values such as 0300 and 0000, and then repeats selected values under the opposite polarity and with trailing blanking off. That way each chain's effect is seen apart from the other's.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

  localparam int unsigned SEG_W = 7;
  localparam int unsigned BCD_W = 4;

  typedef struct packed {
    logic clear;
    logic load;
  } segStrobe_t;

  // Active-high glyph, a at bit 6 down to g at bit 0
  function automatic logic [SEG_W-1:0] glyphOf(input logic [BCD_W-1:0] v);
    logic [SEG_W-1:0] g;
    case (v)
      4'h0: g = 7'h7E;
      4'h1: g = 7'h30;
      4'h2: g = 7'h6D;
      4'h3: g = 7'h79;
      4'h4: g = 7'h33;
      4'h5: g = 7'h5B;
      4'h6: g = 7'h5F;
      4'h7: g = 7'h70;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h7B;
      4'hA: g = 7'h77;
      4'hB: g = 7'h1F;
      4'hC: g = 7'h4E;
      4'hD: g = 7'h3D;
      4'hE: g = 7'h4F;
      default: g = 7'h47;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/rbd_blank_ctrl.sv
module rbd_blank_ctrl
  import rbd_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  parameter int unsigned FRAC_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_DIGITS*BCD_W-1:0] bcdIn,
  input  logic [FRAC_W-1:0]           fracDigits,
  input  logic                        trailBlankEn,
  output logic [NUM_DIGITS-1:0]       blankMask,
  output segStrobe_t                  strobe
);

  logic [NUM_DIGITS-1:0] isZero;
  logic [NUM_DIGITS-1:0] leadInN;   // active-low chain input, top digit down
  logic [NUM_DIGITS-1:0] trailInN;  // active-low chain input, digit 0 up
  logic [NUM_DIGITS-1:0] blankLead;
  logic [NUM_DIGITS-1:0] blankTrail;
  logic [FRAC_W:0]       fracExt;

  assign fracExt = {1'b0, fracDigits};

  // top stage sees an active blanking input; bottom stage sees the enable
  assign leadInN[NUM_DIGITS-1] = 1'b0;
  assign trailInN[0]           = ~trailBlankEn;

  genvar i;
  generate
    for (i = 0; i < NUM_DIGITS; i++) begin : g_stage
      localparam logic [FRAC_W:0] IDX = (FRAC_W+1)'(i);

      assign isZero[i]     = (bcdIn[i*BCD_W +: BCD_W] == '0);
      assign blankLead[i]  = isZero[i] && !leadInN[i] && (IDX > fracExt);
      assign blankTrail[i] = isZero[i] && !trailInN[i] && (IDX < fracExt);
      assign blankMask[i]  = blankLead[i] | blankTrail[i];

      if (i > 0) begin : g_lead_link
        assign leadInN[i-1] = ~blankLead[i];
      end
      if (i < NUM_DIGITS-1) begin : g_trail_link
        assign trailInN[i+1] = ~blankTrail[i];
      end

      // R2
      blank_only_zero_chk: assert property (@(posedge clk) disable iff (rst)
        blankMask[i] |-> (bcdIn[i*BCD_W +: BCD_W] == '0));

      // R3
      int_lsd_lit_chk: assert property (@(posedge clk) disable iff (rst)
        (IDX == fracExt) |-> !blankMask[i]);

      // R7
      trail_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!trailBlankEn && (IDX < fracExt)) |-> !blankMask[i]);

      if (i < NUM_DIGITS-1) begin : g_lead_chk
        // R1
        lead_contig_chk: assert property (@(posedge clk) disable iff (rst)
          (blankMask[i] && (IDX > fracExt)) |-> blankMask[i+1]);
      end
    end
  endgenerate

  assign strobe.clear = rst;
  assign strobe.load  = ~rst;

endmodule

// File: rtl/rbd_seg_path.sv
module rbd_seg_path
  import rbd_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4
) (
  input  logic                        clk,
  input  segStrobe_t                  strobe,
  input  logic [NUM_DIGITS*BCD_W-1:0] bcdIn,
  input  logic [NUM_DIGITS-1:0]       blankMask,
  input  logic                        anodeCommon,
  output logic [NUM_DIGITS*SEG_W-1:0] segOut
);

  localparam int unsigned OUT_W = NUM_DIGITS * SEG_W;

  logic [OUT_W-1:0] segNext;

  genvar i;
  generate
    for (i = 0; i < NUM_DIGITS; i++) begin : g_digit
      logic [SEG_W-1:0] litPattern;
      assign litPattern = blankMask[i] ? '0 : glyphOf(bcdIn[i*BCD_W +: BCD_W]);
      assign segNext[i*SEG_W +: SEG_W] = litPattern ^ {SEG_W{anodeCommon}};

      // R9
      blank_dark_chk: assert property (@(posedge clk) disable iff (strobe.clear)
        (strobe.load && blankMask[i]) |=>
          (segOut[i*SEG_W +: SEG_W] == {SEG_W{$past(anodeCommon)}}));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      segOut <= {OUT_W{anodeCommon}};
    end else if (strobe.load) begin
      segOut <= segNext;
    end
  end

  // R10
  reset_dark_chk: assert property (@(posedge clk)
    strobe.clear |=> (segOut == {OUT_W{$past(anodeCommon)}}));

endmodule

// File: rtl/rbd_display_decoder.sv
module rbd_display_decoder
  import rbd_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned FRAC_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int unsigned IN_W   = NUM_DIGITS * BCD_W,
  localparam int unsigned OUT_W  = NUM_DIGITS * SEG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   bcdIn,
  input  logic              anodeCommon,
  input  logic [FRAC_W-1:0] fracDigits,
  input  logic              trailBlankEn,
  output logic [OUT_W-1:0]  segOut
);

  logic [NUM_DIGITS-1:0] blankMask;
  segStrobe_t            strobe;

  rbd_blank_ctrl #(
    .NUM_DIGITS(NUM_DIGITS),
    .FRAC_W    (FRAC_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .bcdIn       (bcdIn),
    .fracDigits  (fracDigits),
    .trailBlankEn(trailBlankEn),
    .blankMask   (blankMask),
    .strobe      (strobe)
  );

  rbd_seg_path #(
    .NUM_DIGITS(NUM_DIGITS)
  ) u_path (
    .clk        (clk),
    .strobe     (strobe),
    .bcdIn      (bcdIn),
    .blankMask  (blankMask),
    .anodeCommon(anodeCommon),
    .segOut     (segOut)
  );

endmodule

// File: tb/rbd_display_decoder_tb.sv
module rbd_display_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ND = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bcdIn = '0;
  logic        anodeCommon = 1'b0;
  logic [1:0]  fracDigits = '0;
  logic        trailBlankEn = 1'b0;
  logic [27:0] segOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  logic [27:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rbd_display_decoder u_dut (
    .clk(clk), .rst(rst), .bcdIn(bcdIn), .anodeCommon(anodeCommon),
    .fracDigits(fracDigits), .trailBlankEn(trailBlankEn), .segOut(segOut)
  );

  // R4 glyph encodings
  function automatic logic [6:0] refGlyph(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h7E, 7'h30, 7'h6D, 7'h79, 7'h33, 7'h5B, 7'h5F, 7'h70,
                           7'h7F, 7'h7B, 7'h77, 7'h1F, 7'h4E, 7'h3D, 7'h4F, 7'h47};
    return t[v];
  endfunction

  function automatic logic [27:0] model(input logic r, input logic [15:0] v,
                                        input logic pol, input int f, input logic tr);
    logic [27:0] o;
    bit blank [ND];
    bit act;
    for (int i = 0; i < ND; i++) blank[i] = 0;
    act = 1;                                   // R1 leading chain
    for (int i = ND-1; i >= 0; i--) begin
      if (i > f && act && v[i*4 +: 4] == 0) blank[i] = 1;
      else act = 0;
    end
    act = tr;                                  // R7 trailing chain
    for (int i = 0; i < ND; i++) begin
      if (i < f && act && v[i*4 +: 4] == 0) blank[i] = 1;
      else act = 0;
    end
    for (int i = 0; i < ND; i++)
      o[i*7 +: 7] = (blank[i] || r) ? 7'h00 : refGlyph(v[i*4 +: 4]);
    return pol ? ~o : o;                       // R5
  endfunction

  task automatic drive(input logic r, input logic [15:0] v, input logic pol,
                       input int f, input logic tr, input string tag);
    @(negedge clk);
    rst = r; bcdIn = v; anodeCommon = pol; fracDigits = 2'(f); trailBlankEn = tr;
    expQ.push_back(model(r, v, pol, f, tr));
    tagQ.push_back(tag);
  endtask

  // monitor: result visible after the capturing edge (R9)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [27:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        testsRun++;
        if (segOut !== e) begin
          testsFailed++;
          $display("FAIL %s: segOut=%h expected=%h", t, segOut, e);
        end
      end
    end
  end

  initial begin
    drive(1, 16'h1234, 0, 0, 0, "R10 reset cathode");
    drive(0, 16'h0100, 0, 0, 0, "R1 value 100");
    drive(0, 16'h0217, 0, 0, 0, "R1 value 217");
    drive(0, 16'h1024, 0, 0, 0, "R1 value 1024");
    drive(0, 16'h0905, 0, 0, 0, "R2 internal zero");
    drive(0, 16'h0000, 0, 0, 0, "R3 single zero");
    drive(0, 16'hABCD, 0, 0, 0, "R4 hex glyphs");
    drive(0, 16'hEF89, 0, 0, 0, "R4 hex glyphs 2");
    drive(0, 16'h5674, 0, 0, 0, "R4 digits 4-7");
    drive(0, 16'h0100, 1, 0, 0, "R5 anode polarity");
    drive(0, 16'h0000, 1, 0, 0, "R5 anode blanks");
    drive(0, 16'h0012, 0, 2, 0, "R6 fraction stops lead chain");
    drive(0, 16'h0300, 0, 2, 1, "R7 trailing blank 3.00");
    drive(0, 16'h0300, 0, 2, 0, "R7 trailing disabled");
    drive(0, 16'h1250, 0, 2, 1, "R7 partial trailing");
    drive(0, 16'h0450, 0, 0, 1, "R8 integer zeros kept");
    drive(0, 16'h0000, 0, 3, 1, "R3 R7 all fraction zero");
    drive(0, 16'h0000, 1, 1, 1, "R5 R7 anode trailing");
    drive(1, 16'h9999, 1, 0, 0, "R10 reset anode");
    drive(0, 16'h9999, 1, 0, 0, "R9 after reset");
    @(negedge clk);
    rst = 1'b0;
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule